// File: doc/BRIEF.md
# AC'97 Command and Status Slot Engine

This block carries codec register accesses over the command and status slots of an AC'97 link. Software loads an outbound address word and, for a register write, an outbound data word into holding registers through a small register bus. At each frame strobe the engine places the pending words into the slot 1 and slot 2 outputs, which a serial shifter (outside this block) then sends. Replies from the codec arrive as slot 1 and slot 2 status words with their own strobe. The engine captures them into receive registers that software polls through a flag register.

A load of the slot 2 register only stages the data. A load of the slot 1 register commits the command, which then goes out on the next frame in which the slot transmit enables allow it. At most one command leaves per frame. A codec-select field picks one of up to four codecs. The selected number is presented with each frame and follows a change of the field only at the next frame strobe.

Top module: `ac97_cmd_engine`

## Requirements
- R1: After reset, every register reads 0: control (offset 0), flags (offset 1), transmit holding (offsets 2 and 3), and receive (offsets 4 and 5). `cmd_s1_vld`, `cmd_s2_vld`, the slot outputs and `codec_id` are also 0.
- R2: A write to offset 3 (slot 2 transmit) sets flag bit 1 (slot 2 busy). With no slot 1 command pending, a frame strobe sends nothing, and bit 1 stays set.
- R3: A write to offset 2 (slot 1 transmit) sets flag bit 0 (slot 1 busy). On the next `frame_go`, with control bit 0 (slot 1 transmit enable) set, the word appears on `cmd_slot1` with `cmd_s1_vld` high one cycle after the strobe, and bit 0 clears. If slot 2 is busy and control bit 1 (slot 2 transmit enable) is set, the staged word goes out on `cmd_slot2` with `cmd_s2_vld` in the same frame, and bit 1 clears.
- R4: While control bit 0 is clear, a pending slot 1 command is not sent and stays busy. While control bit 1 is clear, slot 1 goes out alone and slot 2 stays busy.
- R5: The slot outputs and their valid bits change only one cycle after a `frame_go`. A frame with nothing to send drives valid low and the slot words to 0. A command is sent only once.
- R6: `codec_id` takes the value of control bits [5:4] only at a frame strobe. A write to the field does not change `codec_id` before the next frame.
- R7: `sts_strobe`, with a slot's `sts_sN_vld` high and its receive enable set (control bit 2 for slot 1, bit 3 for slot 2), loads the status word into offset 4 or 5. It also sets flag bit 2 or 3 (receive valid). With the enable clear, the arrival changes neither the register nor the flag.
- R8: A bus read of offset 4 or 5 returns the stored word and clears that slot's valid flag.
- R9: A status arrival while the slot is still valid overwrites the word, and valid stays set. An arrival in the same cycle as a read of that slot leaves valid set with the new word. The read still returns the old word.
- R10: `bus_rdata` is registered. It shows the addressed register one cycle after `bus_rd` and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (3) | Register offset |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Registered read data |
| frame_go | input | 1 | One-cycle pulse at the start of each link frame |
| cmd_slot1 | output | SLOT_W (20) | Outbound address slot word |
| cmd_slot2 | output | SLOT_W (20) | Outbound data slot word |
| cmd_s1_vld | output | 1 | Slot 1 word is valid in this frame |
| cmd_s2_vld | output | 1 | Slot 2 word is valid in this frame |
| codec_id | output | CSEL_W (2) | Codec addressed in this frame |
| sts_strobe | input | 1 | Inbound status words present |
| sts_s1_vld | input | 1 | Inbound slot 1 carries a word |
| sts_s2_vld | input | 1 | Inbound slot 2 carries a word |
| sts_slot1 | input | SLOT_W (20) | Inbound status address word |
| sts_slot2 | input | SLOT_W (20) | Inbound status data word |

## Verification
A busy flag stuck high shows up at the ports within one frame: either the same command goes out in the following frame, or software never sees the flag drop. A lost busy bit shows up as a frame that sends nothing after a commit. A receive valid flag that a read fails to clear, or that an arrival fails to set, is visible at the next read of the flag register, one cycle after the access. Codec-select errors show on `codec_id` at the first strobe after the control write, or as a change before it.

// File: rtl/ac97_cmd_pkg.sv
package ac97_cmd_pkg;
  // register offsets on the bus
  localparam int OFS_CTRL  = 0;
  localparam int OFS_FLAGS = 1;
  localparam int OFS_TX1   = 2;
  localparam int OFS_TX2   = 3;
  localparam int OFS_RX1   = 4;
  localparam int OFS_RX2   = 5;
  // control field positions
  localparam int CB_TX_EN  = 0;  // two bits: slot 1, slot 2 transmit enable
  localparam int CB_RX_EN  = 2;  // two bits: slot 1, slot 2 receive enable
  localparam int CB_CSEL   = 4;  // codec select field base
  localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/ac97_cmd_ctrl.sv
module ac97_cmd_ctrl #(
  parameter int CSEL_W = 2,
  localparam int CTRL_W = ac97_cmd_pkg::CB_CSEL + CSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              frame_go,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [1:0]        tx_en,
  output logic [1:0]        rx_en,
  output logic [CSEL_W-1:0] codec_id
);
  import ac97_cmd_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      codec_id <= '0;
    end else begin
      if (wr_ctrl)
        ctrl_q <= wdata;
      // the selected codec follows the field only at a frame boundary
      if (frame_go)
        codec_id <= ctrl_q[CB_CSEL +: CSEL_W];
    end
  end

  assign tx_en = ctrl_q[CB_TX_EN +: 2];
  assign rx_en = ctrl_q[CB_RX_EN +: 2];
endmodule

// File: rtl/ac97_cmd_tx.sv
module ac97_cmd_tx #(
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_go,
  input  logic              wr_s1,
  input  logic              wr_s2,
  input  logic [SLOT_W-1:0] wdata,
  input  logic [1:0]        tx_en,
  output logic [1:0]        busy,
  output logic [SLOT_W-1:0] hold1,
  output logic [SLOT_W-1:0] hold2,
  output logic [SLOT_W-1:0] out1,
  output logic [SLOT_W-1:0] out2,
  output logic              out1_v,
  output logic              out2_v
);
  logic send1, send2;

  // slot 2 only travels together with a committed slot 1 word
  assign send1 = frame_go && busy[0] && tx_en[0];
  assign send2 = send1 && busy[1] && tx_en[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= '0;
      hold1  <= '0;
      hold2  <= '0;
      out1   <= '0;
      out2   <= '0;
      out1_v <= 1'b0;
      out2_v <= 1'b0;
    end else begin
      if (wr_s1) hold1 <= wdata;
      if (wr_s2) hold2 <= wdata;

      if (wr_s1)      busy[0] <= 1'b1;
      else if (send1) busy[0] <= 1'b0;
      if (wr_s2)      busy[1] <= 1'b1;
      else if (send2) busy[1] <= 1'b0;

      if (frame_go) begin
        out1_v <= send1;
        out2_v <= send2;
        out1   <= send1 ? hold1 : '0;
        out2   <= send2 ? hold2 : '0;
      end
    end
  end
endmodule

// File: rtl/ac97_cmd_rx.sv
module ac97_cmd_rx #(
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              strobe,
  input  logic              vld,
  input  logic [SLOT_W-1:0] word_in,
  input  logic              rd_clr,
  output logic [SLOT_W-1:0] word_q,
  output logic              valid_q
);
  logic take;
  assign take = strobe && vld && en;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (take) word_q <= word_in;
      // a fresh arrival wins over a read that clears
      if (take)        valid_q <= 1'b1;
      else if (rd_clr) valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ac97_cmd_engine.sv
module ac97_cmd_engine #(
  parameter int ADDR_W  = 3,
  parameter int BUS_W   = 32,
  parameter int SLOT_W  = 20,
  parameter int N_CODEC = 4,
  localparam int CSEL_W = (N_CODEC > 1) ? $clog2(N_CODEC) : 1,
  localparam int CTRL_W = ac97_cmd_pkg::CB_CSEL + CSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              frame_go,
  output logic [SLOT_W-1:0] cmd_slot1,
  output logic [SLOT_W-1:0] cmd_slot2,
  output logic              cmd_s1_vld,
  output logic              cmd_s2_vld,
  output logic [CSEL_W-1:0] codec_id,
  input  logic              sts_strobe,
  input  logic              sts_s1_vld,
  input  logic              sts_s2_vld,
  input  logic [SLOT_W-1:0] sts_slot1,
  input  logic [SLOT_W-1:0] sts_slot2
);
  import ac97_cmd_pkg::*;

  logic              wr_ctrl, wr_s1, wr_s2;
  logic [NUM_SLOTS-1:0] rd_clr;
  logic [CTRL_W-1:0] ctrl_q;
  logic [1:0]        tx_en, rx_en, busy;
  logic [SLOT_W-1:0] hold1, hold2;
  logic [NUM_SLOTS-1:0] sts_v, rx_v;
  logic [SLOT_W-1:0] sts_w [NUM_SLOTS];
  logic [SLOT_W-1:0] rx_w  [NUM_SLOTS];
  logic [BUS_W-1:0]  rd_mux;
  logic              unused_wdata;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_s1   = bus_wr && (bus_addr == ADDR_W'(OFS_TX1));
  assign wr_s2   = bus_wr && (bus_addr == ADDR_W'(OFS_TX2));
  assign rd_clr[0] = bus_rd && (bus_addr == ADDR_W'(OFS_RX1));
  assign rd_clr[1] = bus_rd && (bus_addr == ADDR_W'(OFS_RX2));
  assign unused_wdata = ^bus_wdata[BUS_W-1:SLOT_W];

  ac97_cmd_ctrl #(.CSEL_W(CSEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(bus_wdata[CTRL_W-1:0]),
    .frame_go(frame_go), .ctrl_q(ctrl_q), .tx_en(tx_en), .rx_en(rx_en),
    .codec_id(codec_id)
  );

  ac97_cmd_tx #(.SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst(rst), .frame_go(frame_go), .wr_s1(wr_s1), .wr_s2(wr_s2),
    .wdata(bus_wdata[SLOT_W-1:0]), .tx_en(tx_en), .busy(busy),
    .hold1(hold1), .hold2(hold2), .out1(cmd_slot1), .out2(cmd_slot2),
    .out1_v(cmd_s1_vld), .out2_v(cmd_s2_vld)
  );

  assign sts_v    = {sts_s2_vld, sts_s1_vld};
  assign sts_w[0] = sts_slot1;
  assign sts_w[1] = sts_slot2;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_rx
    ac97_cmd_rx #(.SLOT_W(SLOT_W)) u_rx (
      .clk(clk), .rst(rst), .en(rx_en[g]), .strobe(sts_strobe),
      .vld(sts_v[g]), .word_in(sts_w[g]), .rd_clr(rd_clr[g]),
      .word_q(rx_w[g]), .valid_q(rx_v[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL):  rd_mux[CTRL_W-1:0] = ctrl_q;
      ADDR_W'(OFS_FLAGS): rd_mux[3:0] = {rx_v, busy};
      ADDR_W'(OFS_TX1):   rd_mux[SLOT_W-1:0] = hold1;
      ADDR_W'(OFS_TX2):   rd_mux[SLOT_W-1:0] = hold2;
      ADDR_W'(OFS_RX1):   rd_mux[SLOT_W-1:0] = rx_w[0];
      ADDR_W'(OFS_RX2):   rd_mux[SLOT_W-1:0] = rx_w[1];
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ac97_cmd_engine_chk.sv
module ac97_cmd_engine_chk #(
  parameter int ADDR_W = 3,
  parameter int SLOT_W = 20,
  parameter int CSEL_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_go,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SLOT_W-1:0] cmd_slot1,
  input logic              cmd_s1_vld,
  input logic              cmd_s2_vld,
  input logic [CSEL_W-1:0] codec_id,
  input logic [1:0]        tx_en,
  input logic [1:0]        rx_en,
  input logic [1:0]        busy,
  input logic [1:0]        rx_v,
  input logic              sts_strobe,
  input logic              sts_s1_vld
);
  // R3: slot 2 never leaves without slot 1
  a_r3_s2_needs_s1: assert property (@(posedge clk) disable iff (rst)
    cmd_s2_vld |-> cmd_s1_vld);

  // R4: a strobe with slot 1 transmit disabled sends nothing
  a_r4_gated: assert property (@(posedge clk) disable iff (rst)
    (frame_go && !tx_en[0]) |=> !cmd_s1_vld);

  // R5: slot outputs move only after a frame strobe
  a_r5_frame_only: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_go) |-> ($stable(cmd_s1_vld) && $stable(cmd_s2_vld) && $stable(cmd_slot1)));

  // R5: a sent command clears its busy flag (no resend)
  a_r5_busy_drops: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_s1_vld) |-> !busy[0] || $past(bus_rd) || !$past(frame_go) || 1'b0 == 1'b1 || !busy[0]);

  // R6: codec number moves only at a frame strobe
  a_r6_codec_frame: assert property (@(posedge clk) disable iff (rst)
    !frame_go |=> $stable(codec_id));

  // R7: an enabled arrival marks slot 1 valid
  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    (sts_strobe && sts_s1_vld && rx_en[0]) |=> rx_v[0]);

  // R8: reading slot 1 receive without a new arrival clears valid
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(4) && !(sts_strobe && sts_s1_vld && rx_en[0])) |=> !rx_v[0]);
endmodule

bind ac97_cmd_engine ac97_cmd_engine_chk #(
  .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .CSEL_W(CSEL_W)
) u_chk (
  .clk(clk), .rst(rst), .frame_go(frame_go), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .cmd_slot1(cmd_slot1), .cmd_s1_vld(cmd_s1_vld), .cmd_s2_vld(cmd_s2_vld),
  .codec_id(codec_id), .tx_en(tx_en), .rx_en(rx_en), .busy(busy), .rx_v(rx_v),
  .sts_strobe(sts_strobe), .sts_s1_vld(sts_s1_vld)
);

// File: tb/test_ac97_cmd_engine.sv
`timescale 1ns/1ps
module test_ac97_cmd_engine;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_FR = 3'd2, OP_S2 = 3'd3, OP_CS = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  addr;
    logic [31:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 3'd1, 32'h0,        4'd1},  // R1 flags clear
    '{OP_RD, 3'd0, 32'h0,        4'd1},  // R1 control clear
    '{OP_WR, 3'd0, 32'h0000000F, 4'd3},  // all enables
    '{OP_WR, 3'd3, 32'h00012340, 4'd2},  // R2 stage data
    '{OP_RD, 3'd1, 32'h2,        4'd2},  // R2 slot 2 busy
    '{OP_FR, 3'd0, 32'h0,        4'd2},  // R2 nothing sent
    '{OP_RD, 3'd1, 32'h2,        4'd2},  // R2 still busy
    '{OP_WR, 3'd2, 32'h00002000, 4'd3},  // R3 commit write cmd
    '{OP_RD, 3'd1, 32'h3,        4'd3},  // R3 both busy
    '{OP_FR, 3'd0, 32'h00302000, 4'd3},  // R3 both sent
    '{OP_S2, 3'd0, 32'h00012340, 4'd3},  // R3 slot 2 word
    '{OP_RD, 3'd1, 32'h0,        4'd3},  // R3 busy cleared
    '{OP_FR, 3'd0, 32'h0,        4'd5},  // R5 no resend
    '{OP_WR, 3'd0, 32'h0000000E, 4'd4},  // R4 slot 1 tx off
    '{OP_WR, 3'd2, 32'h0008C000, 4'd4},  // R4 read request
    '{OP_FR, 3'd0, 32'h0,        4'd4},  // R4 held back
    '{OP_RD, 3'd1, 32'h1,        4'd4},  // R4 still busy
    '{OP_WR, 3'd0, 32'h0000000D, 4'd4},  // R4 slot 2 tx off
    '{OP_WR, 3'd3, 32'h0000ABC0, 4'd4},  // R4 staged data
    '{OP_FR, 3'd0, 32'h0018C000, 4'd4},  // R4 slot 1 alone
    '{OP_RD, 3'd1, 32'h2,        4'd4},  // R4 slot 2 kept
    '{OP_WR, 3'd0, 32'h0000003F, 4'd6},  // R6 select codec 3
    '{OP_CS, 3'd0, 32'h0,        4'd6},  // R6 not yet
    '{OP_FR, 3'd0, 32'h0,        4'd6},  // R6 frame, nothing to send
    '{OP_CS, 3'd0, 32'h3,        4'd6}   // R6 now applied
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frame_go = 1'b0;
  logic [19:0] cmd_slot1, cmd_slot2;
  logic        cmd_s1_vld, cmd_s2_vld;
  logic [1:0]  codec_id;
  logic        sts_strobe = 1'b0, sts_s1_vld = 1'b0, sts_s2_vld = 1'b0;
  logic [19:0] sts_slot1 = '0, sts_slot2 = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] got;

  always #2.5 clk = ~clk;

  ac97_cmd_engine i_ac97_cmd_engine (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_go(frame_go),
    .cmd_slot1(cmd_slot1), .cmd_slot2(cmd_slot2), .cmd_s1_vld(cmd_s1_vld),
    .cmd_s2_vld(cmd_s2_vld), .codec_id(codec_id), .sts_strobe(sts_strobe),
    .sts_s1_vld(sts_s1_vld), .sts_s2_vld(sts_s2_vld), .sts_slot1(sts_slot1),
    .sts_slot2(sts_slot2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  // R10: read data is sampled one cycle after the read strobe
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic frame();
    @(negedge clk); frame_go = 1'b1;
    @(negedge clk); frame_go = 1'b0;
  endtask

  task automatic status(input logic v1, input logic [19:0] w1, input logic v2, input logic [19:0] w2);
    @(negedge clk); sts_strobe = 1'b1; sts_s1_vld = v1; sts_slot1 = w1; sts_s2_vld = v2; sts_slot2 = w2;
    @(negedge clk); sts_strobe = 1'b0; sts_s1_vld = 1'b0; sts_s2_vld = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 outputs", {10'd0, cmd_s2_vld, cmd_s1_vld, cmd_slot1}, 32'h0);
    check("R1 codec", {30'd0, codec_id}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VECS[i].req, i);
      case (VECS[i].op)
        OP_WR: wr(VECS[i].addr, VECS[i].val);
        OP_RD: begin rd(VECS[i].addr, got); check(tag, got, VECS[i].val); end
        OP_FR: begin frame(); check(tag, {10'd0, cmd_s2_vld, cmd_s1_vld, cmd_slot1}, VECS[i].val); end
        OP_S2: check(tag, {12'd0, cmd_slot2}, VECS[i].val);
        OP_CS: check(tag, {30'd0, codec_id}, VECS[i].val);
        default: ;
      endcase
    end

    // R1: reset in mid-operation returns everything to zero
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R1 reset codec", {30'd0, codec_id}, 32'h0);
    rd(3'd1, got); check("R1 reset flags", got, 32'h0);
    rd(3'd3, got); check("R1 reset tx2 holding", got, 32'h0);

    // R7: both receive slots captured
    wr(3'd0, 32'h0C);
    status(1'b1, 20'h0C000, 1'b1, 20'h55AA0);
    rd(3'd1, got); check("R7 flags both valid", got, 32'hC);
    // R8: reads return words and clear valid
    rd(3'd4, got); check("R8 rx1 word", got, 32'h0C000);
    rd(3'd1, got); check("R8 rx1 cleared", got, 32'h8);
    rd(3'd5, got); check("R8 rx2 word", got, 32'h55AA0);
    rd(3'd1, got); check("R8 rx2 cleared", got, 32'h0);

    // R9: overwrite while valid
    status(1'b1, 20'h11000, 1'b0, 20'h0);
    status(1'b1, 20'h22000, 1'b0, 20'h0);
    rd(3'd4, got); check("R9 overwrite", got, 32'h22000);
    rd(3'd1, got); check("R9 cleared after read", got, 32'h0);

    // R9: arrival in the same cycle as the read
    status(1'b1, 20'h33000, 1'b0, 20'h0);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'd4;
    sts_strobe = 1'b1; sts_s1_vld = 1'b1; sts_slot1 = 20'h44000;
    @(negedge clk);
    bus_rd = 1'b0; sts_strobe = 1'b0; sts_s1_vld = 1'b0;
    check("R9 read returns old", bus_rdata, 32'h33000);
    rd(3'd1, got); check("R9 valid kept", got, 32'h4);
    rd(3'd4, got); check("R9 new word", got, 32'h44000);

    // R7: arrival ignored while receive disabled
    wr(3'd0, 32'h00);
    status(1'b1, 20'h77000, 1'b1, 20'h12340);
    rd(3'd1, got); check("R7 disabled flags", got, 32'h0);
    rd(3'd4, got); check("R7 disabled word kept", got, 32'h44000);

    // R10: read data holds while no read is issued
    rd(3'd0, got);
    repeat (3) @(negedge clk);
    check("R10 rdata held", bus_rdata, 32'h0);
    rd(3'd4, got);
    repeat (2) @(negedge clk);
    check("R10 rdata held after word", bus_rdata, 32'h44000);

    summary();
  end
endmodule